// File: doc/BRIEF.md
# QoS Priority Level Controller

This block sets the transaction priority levels (urgency, pressure and hurry) for one initiator port of an on-chip interconnect. It also gates a credit-style bandwidth limiter. A single 32-bit control register with four live bits sets the behaviour. An asynchronous threshold input can do two things:

- choose between two programmed priority values;
- switch the limiter on and off.

Socket-supplied pressure and hurry levels can be merged with the generated levels by taking the larger of the two.

The limiter keeps a byte counter. Transferred bytes are added to it, and a programmed rate is removed on each accounting tick. The counter saturates at zero and at full scale, and a stall is raised while the counter is above a programmed burst threshold. Accounting ticks come from the port clock or from a synchronized external reference tick. A build option selects whether that external tick exists.

Top module: `qos_level_ctrl`

## Requirements
- R1: After reset the register reads 0, urgency, pressure and hurry all equal `prio_p0`, `lim_count` is 0 and `lim_stall` is 0.
- R2: A register write is visible on `reg_rdata` from the cycle after the write edge. Until that edge the old value is read. Bits 31..4 always read 0. Bit 3 is limit-gating enable, bit 2 is port-clock accounting, bit 1 is threshold priority select and bit 0 is socket merge.
- R3: With bit 1 set, all three levels equal `prio_p0` while the synchronized threshold is low and `prio_p1` while it is high. A threshold change is visible two clock edges after it is applied. With bit 1 clear, the levels use `prio_p0` and the threshold has no effect on them.
- R4: With bit 0 set, pressure and hurry each equal the larger of the socket level and the generated level, and urgency stays at the generated level. With bit 0 clear, the socket levels are ignored.
- R5: With bit 3 set and the synchronized threshold low, the counter is cleared to 0 on the next edge and held there, and the stall output is 0.
- R6: With bit 3 set and the synchronized threshold high, the limiter counts and raises the stall.
- R7: With bit 3 clear, the limiter counts regardless of the threshold input.
- R8: On each counting edge the counter becomes count + bytes (if `xfer_valid`) − rate (if a tick is present), clamped to the range 0..2^CNT_W−1. `lim_stall` is high exactly when the limiter is counting and `lim_count > cfg_burst`.
- R9: With bit 2 set, the rate is removed on every clock edge. With bit 2 clear and the external reference present, the rate is removed once for each rising edge of `ext_tick_in`, on the third clock edge after that rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Current control register value |
| ext_thr_in | input | 1 | Asynchronous external threshold |
| ext_tick_in | input | 1 | Asynchronous external reference tick |
| sock_press | input | LVL_W | Socket pressure level |
| sock_hurry | input | LVL_W | Socket hurry level |
| prio_p0 | input | LVL_W | Priority value used when threshold low |
| prio_p1 | input | LVL_W | Priority value used when threshold high |
| cfg_rate | input | CNT_W | Bytes removed per accounting tick |
| cfg_burst | input | CNT_W | Stall threshold for the counter |
| xfer_valid | input | 1 | A transfer completes this cycle |
| xfer_bytes | input | BYTE_W | Bytes of that transfer |
| urgency | output | LVL_W | Final urgency level |
| pressure | output | LVL_W | Final pressure level |
| hurry | output | LVL_W | Final hurry level |
| lim_stall | output | 1 | Limiter requests a stall |
| lim_count | output | CNT_W | Limiter byte counter |

## Verification
The three levels respond to socket and priority inputs in the same cycle. A register write shows on the read port after one edge, and a threshold change reaches the levels after two edges. A rise of the reference tick reaches the counter on the third edge. A transfer or a rate removal changes the counter after one edge, and the stall follows the counter combinationally. Every bench check drives its inputs just after an edge, waits exactly the number of edges given above, and samples two nanoseconds after that edge. Several checks also sample one edge early to confirm that the old value still holds.

// File: rtl/qos_ctrl_pkg.sv
package qos_ctrl_pkg;

   // Control bit positions (software-visible layout)
   localparam int unsigned CTRL_SOCK_BIT   = 0;
   localparam int unsigned CTRL_THRSEL_BIT = 1;
   localparam int unsigned CTRL_PCLK_BIT   = 2;
   localparam int unsigned CTRL_LIMGATE_BIT = 3;
   localparam int unsigned CTRL_LIVE_BITS  = 4;

   typedef struct packed {
      logic lim_gate_en;   // bit 3
      logic port_clk_en;   // bit 2
      logic thr_sel_en;    // bit 1
      logic sock_merge_en; // bit 0
   } qos_ctrl_t;

endpackage

// File: rtl/qos_ctrl_reg.sv
module qos_ctrl_reg
   import qos_ctrl_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output qos_ctrl_t        ctrl,
   output logic [REG_W-1:0] rdata
);

   localparam int unsigned PAD_W = REG_W - CTRL_LIVE_BITS;

   qos_ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q.lim_gate_en   <= wdata[CTRL_LIMGATE_BIT];
         ctrl_q.port_clk_en   <= wdata[CTRL_PCLK_BIT];
         ctrl_q.thr_sel_en    <= wdata[CTRL_THRSEL_BIT];
         ctrl_q.sock_merge_en <= wdata[CTRL_SOCK_BIT];
      end
   end

   assign ctrl  = ctrl_q;
   assign rdata = {{PAD_W{1'b0}}, ctrl_q};

endmodule

// File: rtl/qos_sync_edge.sv
module qos_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level_out,
   output logic rise_out
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q[0] <= async_in;
         prev_q     <= chain_q[STAGES-1];
      end
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign level_out = chain_q[STAGES-1];
   assign rise_out  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/qos_bw_limiter.sv
module qos_bw_limiter #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tick,
   input  logic              xfer_valid,
   input  logic [BYTE_W-1:0] xfer_bytes,
   input  logic [CNT_W-1:0]  rate,
   input  logic [CNT_W-1:0]  burst,
   output logic [CNT_W-1:0]  count,
   output logic              stall
);

   localparam int unsigned SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] sum_w;
   logic [CNT_W-1:0] sat_w;
   logic [CNT_W-1:0] dec_w;
   logic [CNT_W-1:0] nxt_w;

   always_comb begin
      sum_w = {1'b0, cnt_q} + (xfer_valid ? SUM_W'(xfer_bytes) : '0);
      sat_w = sum_w[CNT_W] ? '1 : sum_w[CNT_W-1:0];
      dec_w = tick ? rate : '0;
      nxt_w = (sat_w > dec_w) ? (sat_w - dec_w) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!active) cnt_q <= '0;
      else              cnt_q <= nxt_w;
   end

   assign count = cnt_q;
   assign stall = active && (cnt_q > burst);

endmodule

// File: rtl/qos_level_mux.sv
module qos_level_mux #(
   parameter int unsigned LVL_W = 2
) (
   input  logic             thr_sel_en,
   input  logic             sock_merge_en,
   input  logic             thr_level,
   input  logic [LVL_W-1:0] prio_p0,
   input  logic [LVL_W-1:0] prio_p1,
   input  logic [LVL_W-1:0] sock_press,
   input  logic [LVL_W-1:0] sock_hurry,
   output logic [LVL_W-1:0] urgency,
   output logic [LVL_W-1:0] pressure,
   output logic [LVL_W-1:0] hurry
);

   logic [LVL_W-1:0] gen_lvl;

   always_comb begin
      gen_lvl = (thr_sel_en && thr_level) ? prio_p1 : prio_p0;
      urgency = gen_lvl;
      if (sock_merge_en) begin
         pressure = (sock_press > gen_lvl) ? sock_press : gen_lvl;
         hurry    = (sock_hurry > gen_lvl) ? sock_hurry : gen_lvl;
      end else begin
         pressure = gen_lvl;
         hurry    = gen_lvl;
      end
   end

endmodule

// File: rtl/qos_level_ctrl.sv
module qos_level_ctrl
   import qos_ctrl_pkg::*;
#(
   parameter int unsigned REG_W       = 32,
   parameter int unsigned LVL_W       = 2,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          USE_EXT_REF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              ext_thr_in,
   input  logic              ext_tick_in,
   input  logic [LVL_W-1:0]  sock_press,
   input  logic [LVL_W-1:0]  sock_hurry,
   input  logic [LVL_W-1:0]  prio_p0,
   input  logic [LVL_W-1:0]  prio_p1,
   input  logic [CNT_W-1:0]  cfg_rate,
   input  logic [CNT_W-1:0]  cfg_burst,
   input  logic              xfer_valid,
   input  logic [BYTE_W-1:0] xfer_bytes,
   output logic [LVL_W-1:0]  urgency,
   output logic [LVL_W-1:0]  pressure,
   output logic [LVL_W-1:0]  hurry,
   output logic              lim_stall,
   output logic [CNT_W-1:0]  lim_count
);

   initial begin : p_param_chk
      assert (REG_W >= CTRL_LIVE_BITS) else $fatal(1, "REG_W too small");
      assert (LVL_W >= 1)              else $fatal(1, "LVL_W must be >= 1");
      assert (CNT_W > BYTE_W)          else $fatal(1, "CNT_W must exceed BYTE_W");
      assert (SYNC_STAGES >= 2)        else $fatal(1, "SYNC_STAGES must be >= 2");
   end

   qos_ctrl_t ctrl;
   logic      thr_sync;
   logic      thr_rise_unused;
   logic      ref_pulse;
   logic      acct_tick;
   logic      lim_active;

   qos_ctrl_reg #(.REG_W(REG_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr_en),
      .wdata (reg_wdata),
      .ctrl  (ctrl),
      .rdata (reg_rdata)
   );

   qos_sync_edge #(.STAGES(SYNC_STAGES)) u_thr_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (ext_thr_in),
      .level_out (thr_sync),
      .rise_out  (thr_rise_unused)
   );

   if (USE_EXT_REF) begin : g_ext_ref
      logic tick_level_unused;
      qos_sync_edge #(.STAGES(SYNC_STAGES)) u_tick_sync (
         .clk       (clk),
         .rst_n     (rst_n),
         .async_in  (ext_tick_in),
         .level_out (tick_level_unused),
         .rise_out  (ref_pulse)
      );
      assign acct_tick = ctrl.port_clk_en | ref_pulse;
   end else begin : g_int_only
      assign ref_pulse = 1'b0;
      assign acct_tick = 1'b1;
   end

   assign lim_active = !ctrl.lim_gate_en || thr_sync;

   qos_bw_limiter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_lim (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (lim_active),
      .tick       (acct_tick),
      .xfer_valid (xfer_valid),
      .xfer_bytes (xfer_bytes),
      .rate       (cfg_rate),
      .burst      (cfg_burst),
      .count      (lim_count),
      .stall      (lim_stall)
   );

   qos_level_mux #(.LVL_W(LVL_W)) u_mux (
      .thr_sel_en    (ctrl.thr_sel_en),
      .sock_merge_en (ctrl.sock_merge_en),
      .thr_level     (thr_sync),
      .prio_p0       (prio_p0),
      .prio_p1       (prio_p1),
      .sock_press    (sock_press),
      .sock_hurry    (sock_hurry),
      .urgency       (urgency),
      .pressure      (pressure),
      .hurry         (hurry)
   );

endmodule

// File: rtl/qos_level_ctrl_chk.sv
module qos_level_ctrl_chk #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned LVL_W = 2,
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_en,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             thr_sync,
   input logic [LVL_W-1:0] sock_press,
   input logic [LVL_W-1:0] sock_hurry,
   input logic [LVL_W-1:0] prio_p0,
   input logic [LVL_W-1:0] urgency,
   input logic [LVL_W-1:0] pressure,
   input logic [LVL_W-1:0] hurry,
   input logic [CNT_W-1:0] lim_count,
   input logic             lim_stall,
   input logic [CNT_W-1:0] cfg_burst
);

   assert_wr_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> reg_rdata[3:0] == $past(reg_wdata[3:0]));

   assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_W-1:4] == '0);

   assert_thr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[1] |-> urgency == prio_p0);

   assert_merge_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[0] |-> (pressure >= sock_press) && (hurry >= sock_hurry)
                       && (pressure >= urgency) && (hurry >= urgency));

   assert_no_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[0] |-> (pressure == urgency) && (hurry == urgency));

   assert_gate_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[3] && !thr_sync |=> lim_count == '0);

   assert_stall_over_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lim_stall |-> lim_count > cfg_burst);

endmodule

bind qos_level_ctrl qos_level_ctrl_chk #(
   .REG_W(REG_W), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr_en  (reg_wr_en),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .thr_sync   (thr_sync),
   .sock_press (sock_press),
   .sock_hurry (sock_hurry),
   .prio_p0    (prio_p0),
   .urgency    (urgency),
   .pressure   (pressure),
   .hurry      (hurry),
   .lim_count  (lim_count),
   .lim_stall  (lim_stall),
   .cfg_burst  (cfg_burst)
);

// File: tb/tb_qos_level_ctrl.sv
`timescale 1ns/1ps
module tb_qos_level_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ext_thr_in = 1'b0;
   logic        ext_tick_in = 1'b0;
   logic [1:0]  sock_press = '0;
   logic [1:0]  sock_hurry = '0;
   logic [1:0]  prio_p0 = 2'd1;
   logic [1:0]  prio_p1 = 2'd3;
   logic [15:0] cfg_rate = '0;
   logic [15:0] cfg_burst = 16'd20;
   logic        xfer_valid = 1'b0;
   logic [7:0]  xfer_bytes = '0;
   logic [1:0]  urgency, pressure, hurry;
   logic        lim_stall;
   logic [15:0] lim_count;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   qos_level_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ext_thr_in(ext_thr_in), .ext_tick_in(ext_tick_in),
      .sock_press(sock_press), .sock_hurry(sock_hurry), .prio_p0(prio_p0),
      .prio_p1(prio_p1), .cfg_rate(cfg_rate), .cfg_burst(cfg_burst),
      .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes), .urgency(urgency),
      .pressure(pressure), .hurry(hurry), .lim_stall(lim_stall), .lim_count(lim_count)
   );

   task automatic cyc(int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] v);
      reg_wr_en = 1'b1;
      reg_wdata = v;
      cyc(1);
      reg_wr_en = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 rdata", reg_rdata, 0);
      chk("R1 urgency", urgency, 1);
      chk("R1 pressure", pressure, 1);
      chk("R1 hurry", hurry, 1);
      chk("R1 count", lim_count, 0);
      chk("R1 stall", lim_stall, 0);
   endtask

   task automatic t_register;
      reg_wr_en = 1'b1;
      reg_wdata = 32'hFFFF_FFF5;
      #1;
      chk("R2 old value before edge", reg_rdata, 0);
      cyc(1);
      reg_wr_en = 1'b0;
      chk("R2 write masked", reg_rdata, 32'h5);
      wr(32'h0);
      chk("R2 cleared", reg_rdata, 0);
   endtask

   task automatic t_thr_levels;
      wr(32'h2);
      chk("R3 low uses p0", urgency, 1);
      ext_thr_in = 1'b1;
      cyc(1);
      chk("R3 one edge still p0", urgency, 1);
      cyc(1);
      chk("R3 urgency p1", urgency, 3);
      chk("R3 pressure p1", pressure, 3);
      chk("R3 hurry p1", hurry, 3);
      wr(32'h0);
      chk("R3 disabled ignores thr", urgency, 1);
      ext_thr_in = 1'b0;
      cyc(3);
   endtask

   task automatic t_socket;
      sock_press = 2'd2;
      sock_hurry = 2'd0;
      wr(32'h1);
      chk("R4 pressure max", pressure, 2);
      chk("R4 hurry max", hurry, 1);
      chk("R4 urgency generator only", urgency, 1);
      sock_hurry = 2'd3;
      #1;
      chk("R4 hurry follows socket", hurry, 3);
      wr(32'h0);
      sock_press = 2'd3;
      #1;
      chk("R4 socket ignored pressure", pressure, 1);
      chk("R4 socket ignored hurry", hurry, 1);
      sock_press = 2'd0;
      sock_hurry = 2'd0;
   endtask

   task automatic t_free_run;
      // gating off, port clock accounting: +10 -3 per edge
      cfg_rate = 16'd3;
      cfg_burst = 16'd20;
      wr(32'h4);
      ext_thr_in = 1'b1; // must be ignored (R7)
      xfer_bytes = 8'd10;
      xfer_valid = 1'b1;
      cyc(2);
      chk("R7 counts with thr high", lim_count, 14);
      chk("R8 stall not yet", lim_stall, 0);
      cyc(1);
      chk("R8 count 21", lim_count, 21);
      chk("R8 stall above burst", lim_stall, 1);
      xfer_valid = 1'b0;
      ext_thr_in = 1'b0;
      cyc(1);
      chk("R9 rate every edge", lim_count, 18);
      chk("R8 stall drops", lim_stall, 0);
      cyc(8);
      chk("R8 saturate at zero", lim_count, 0);
   endtask

   task automatic t_gate;
      cfg_rate = 16'd0;
      xfer_bytes = 8'd50;
      xfer_valid = 1'b1;
      cyc(2);
      chk("R7 accumulate before gating", lim_count, 100);
      wr(32'hC);
      cyc(1);
      chk("R5 cleared when thr low", lim_count, 0);
      cyc(3);
      chk("R5 held at zero", lim_count, 0);
      chk("R5 no stall", lim_stall, 0);
      ext_thr_in = 1'b1;
      cyc(2);
      chk("R6 not yet active", lim_count, 0);
      cyc(1);
      chk("R6 counts when thr high", lim_count, 50);
      chk("R6 stall", lim_stall, 1);
      ext_thr_in = 1'b0;
      cyc(2);
      chk("R6 still active two edges", lim_count, 150);
      cyc(1);
      chk("R5 cleared after thr low", lim_count, 0);
      chk("R5 stall off", lim_stall, 0);
      xfer_valid = 1'b0;
   endtask

   task automatic t_ext_tick;
      cfg_rate = 16'd4;
      wr(32'h0);
      xfer_bytes = 8'd30;
      xfer_valid = 1'b1;
      cyc(1);
      xfer_valid = 1'b0;
      chk("R9 load", lim_count, 30);
      cyc(5);
      chk("R9 no tick no drain", lim_count, 30);
      ext_tick_in = 1'b1;
      cyc(2);
      chk("R9 tick two edges", lim_count, 30);
      cyc(1);
      chk("R9 tick third edge", lim_count, 26);
      cyc(4);
      chk("R9 held tick once", lim_count, 26);
      ext_tick_in = 1'b0;
      cyc(3);
      ext_tick_in = 1'b1;
      cyc(3);
      chk("R9 second tick", lim_count, 22);
      ext_tick_in = 1'b0;
      wr(32'h4);
      chk("R9 write edge old mode", lim_count, 22);
      cyc(1);
      chk("R9 port clock drain", lim_count, 18);
   endtask

   initial begin
      cyc(2);
      rst_n = 1'b1;
      #1;
      t_reset();
      cyc(1);
      t_register();
      t_thr_levels();
      t_socket();
      t_free_run();
      t_gate();
      t_ext_tick();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule